// File: doc/BRIEF.md
# DRAM Clock-Enable Power State Tracker

This block follows the low-power state of a DDR2-class memory device from the controller side and checks the protocol. On every rising clock edge it registers the clock-enable level and a decoded command. It compares that level with the level registered on the previous edge. From that pair, the command, a bank-activity flag and a busy flag, it selects the next power state: normal operation, active power-down, precharge power-down or self-refresh.

Alongside the state it enforces three timing rules. First, a clock-enable level must be held for a minimum number of edges. Second, after self-refresh exit only no-operation commands may be issued for a short window. Third, reads stay blocked for a longer window after that exit. Any sequence outside the allowed set raises a sticky error, which stays set until the controller pulses a reinitialization input. The block is meant to sit next to a memory controller as a live protocol guard, or in a verification environment as a tracker.

Top module: `cke_power_tracker`

## Requirements
- R1: After reset the state output is normal operation (one-hot 4'b0001), the error flag is 0 and read-allowed is 1. State encodings are: bit0 normal, bit1 active power-down, bit2 precharge power-down, bit3 self-refresh.
- R2: Clock-enable sampled high then low with command NOP (code 0) or DESELECT (code 1), while not busy, moves from normal to active power-down if bank_open is 1, or to precharge power-down if bank_open is 0.
- R3: High-to-low clock-enable with AUTOREFRESH (code 2), all banks idle and not busy, enters self-refresh. The same transition with bank_open high sets the error and leaves the state at normal.
- R4: Clock-enable low on two consecutive edges keeps power-down or self-refresh unchanged and ignores the command: even READ (code 3) or OTHER (code 4 to 7) raises no error.
- R5: Low-to-high clock-enable with NOP or DESELECT leaves power-down or self-refresh and returns to normal. Any other command on that edge sets the error and keeps the state.
- R6: After a clock-enable change, the new level must be sampled on 3 consecutive edges (HOLD_EDGES) before it may change again. An earlier change sets the error.
- R7: An attempt to enter power-down or self-refresh while busy is high sets the error and keeps the state at normal.
- R8: After self-refresh exit at edge E, any command other than NOP or DESELECT at edge E+k with k < NRD_CLKS (default 10) sets the error.
- R9: Read-allowed goes low from the self-refresh exit edge E and returns high after edge E+RD_CLKS-1 (default 200). A READ at edge E+k with k < RD_CLKS sets the error; a READ at edge E+RD_CLKS does not.
- R10: Clock-enable high on two consecutive edges in normal state, outside the exit windows, keeps the state unchanged and raises no error for any command.
- R11: The error flag is sticky: once set it stays 1 until an edge with reinit high, which clears it; reinit takes priority over a new error on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reinit | input | 1 | Clears the sticky error flag |
| cke | input | 1 | Clock-enable level at this edge |
| cmd | input | 3 | Decoded command: 0 NOP, 1 DESELECT, 2 AUTOREFRESH, 3 READ, 4-7 other |
| bank_open | input | 1 | 1 when any bank is open, 0 when all banks idle |
| busy | input | 1 | Read, write, mode-register, precharge or refresh in progress |
| state_onehot | output | 4 | Current power state, one-hot |
| err | output | 1 | Sticky illegal-sequence flag |
| read_allowed | output | 1 | High when a READ would be legal |

## Verification
A wrong next-state decision appears on state_onehot one edge after the deciding edge. It usually also raises err on the next command, because later legal stimulus becomes illegal from the wrong state. A miscounted clock-enable hold or exit timer shows up as an err that rises one edge too early or too late near the window boundaries. It may also show as read_allowed changing one cycle off. The bench therefore compares all three outputs after every edge, so any divergence is caught within one cycle of the edge that caused it.

// File: rtl/cke_pkg.sv
package cke_pkg;

    typedef enum logic [3:0] {
        PS_NORMAL   = 4'b0001,
        PS_ACT_PD   = 4'b0010,
        PS_PRE_PD   = 4'b0100,
        PS_SELF_REF = 4'b1000
    } pwr_state_e;

    localparam logic [2:0] CMD_NOP   = 3'd0;
    localparam logic [2:0] CMD_DESEL = 3'd1;
    localparam logic [2:0] CMD_AREF  = 3'd2;
    localparam logic [2:0] CMD_READ  = 3'd3;

    typedef struct packed {
        pwr_state_e next_st;
        logic       illegal;
        logic       sref_exit;
    } step_result_t;

    function automatic logic is_quiet(input logic [2:0] c);
        return (c == CMD_NOP) || (c == CMD_DESEL);
    endfunction

endpackage

// File: rtl/cke_hold_monitor.sv
module cke_hold_monitor #(
    parameter int HOLD_EDGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    output logic cke_prev,
    output logic early_change
);
    localparam int CW = $clog2(HOLD_EDGES + 1);
    localparam logic [CW-1:0] SAT = CW'(HOLD_EDGES);

    logic [CW-1:0] held_q;
    logic          toggled;

    assign toggled      = (cke != cke_prev);
    assign early_change = toggled && (held_q < SAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_prev <= 1'b1;
            held_q   <= SAT;
        end else begin
            cke_prev <= cke;
            if (toggled)
                held_q <= CW'(1);
            else if (held_q < SAT)
                held_q <= held_q + CW'(1);
        end
    end

    // R6: a change right after another change must be flagged
    assert_quick_toggle_R6: assert property (@(posedge clk) disable iff (rst)
        (toggled) |=> (!toggled || early_change));

endmodule

// File: rtl/sref_exit_timer.sv
module sref_exit_timer #(
    parameter int NRD_CLKS = 10,
    parameter int RD_CLKS  = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic cmd_restrict,
    output logic read_ok
);
    localparam int TW = $clog2(RD_CLKS + 1);
    localparam logic [TW-1:0] RD_LIM  = TW'(RD_CLKS);
    localparam logic [TW-1:0] NRD_LIM = TW'(NRD_CLKS);

    logic [TW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)
            since_q <= RD_LIM;
        else if (start)
            since_q <= TW'(1);
        else if (since_q < RD_LIM)
            since_q <= since_q + TW'(1);
    end

    assign cmd_restrict = (since_q < NRD_LIM);
    assign read_ok      = (since_q >= RD_LIM);

    // R9: reads blocked right after an exit
    assert_read_block_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> !read_ok);

    // R8: the quiet window is always inside the read-block window
    assert_window_nest_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_restrict |-> !read_ok);

endmodule

// File: rtl/cke_state_fsm.sv
module cke_state_fsm
    import cke_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reinit,
    input  logic       cke_prev,
    input  logic       cke,
    input  logic [2:0] cmd,
    input  logic       bank_open,
    input  logic       busy,
    input  logic       early_change,
    input  logic       cmd_restrict,
    input  logic       read_ok,
    output pwr_state_e state,
    output logic       err,
    output logic       sref_exit
);
    step_result_t res;
    logic         quiet;

    assign quiet = is_quiet(cmd);

    always_comb begin
        res.next_st   = state;
        res.illegal   = 1'b0;
        res.sref_exit = 1'b0;
        unique case ({cke_prev, cke})
            2'b00: begin
                if (state == PS_NORMAL)
                    res.illegal = 1'b1;
            end
            2'b01: begin
                if (state == PS_NORMAL || !quiet) begin
                    res.illegal = 1'b1;
                end else begin
                    res.next_st   = PS_NORMAL;
                    res.sref_exit = (state == PS_SELF_REF);
                end
            end
            2'b10: begin
                if (state != PS_NORMAL || busy)
                    res.illegal = 1'b1;
                else if (quiet)
                    res.next_st = bank_open ? PS_ACT_PD : PS_PRE_PD;
                else if (cmd == CMD_AREF && !bank_open)
                    res.next_st = PS_SELF_REF;
                else
                    res.illegal = 1'b1;
            end
            default: begin
                if (state != PS_NORMAL)
                    res.illegal = 1'b1;
                else if (cmd_restrict && !quiet)
                    res.illegal = 1'b1;
                else if (cmd == CMD_READ && !read_ok)
                    res.illegal = 1'b1;
            end
        endcase
        if (early_change)
            res.illegal = 1'b1;
    end

    assign sref_exit = res.sref_exit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_NORMAL;
            err   <= 1'b0;
        end else begin
            state <= res.next_st;
            err   <= reinit ? 1'b0 : (err | res.illegal);
        end
    end

    assert_state_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (err && !reinit) |=> err);

    assert_sref_idle_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(state == PS_SELF_REF) |-> $past(!bank_open && !busy && cmd == CMD_AREF));

    assert_entry_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(state == PS_NORMAL) |-> $past(!busy));

    assert_exit_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(state == PS_NORMAL) |-> $past(is_quiet(cmd) && cke));

endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
    import cke_pkg::*;
#(
    parameter int HOLD_EDGES = 3,
    parameter int NRD_CLKS   = 10,
    parameter int RD_CLKS    = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reinit,
    input  logic       cke,
    input  logic [2:0] cmd,
    input  logic       bank_open,
    input  logic       busy,
    output logic [3:0] state_onehot,
    output logic       err,
    output logic       read_allowed
);
    logic       cke_prev;
    logic       early_change;
    logic       cmd_restrict;
    logic       read_ok;
    logic       sref_exit;
    pwr_state_e state;

    cke_hold_monitor #(.HOLD_EDGES(HOLD_EDGES)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .cke          (cke),
        .cke_prev     (cke_prev),
        .early_change (early_change)
    );

    sref_exit_timer #(.NRD_CLKS(NRD_CLKS), .RD_CLKS(RD_CLKS)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .start        (sref_exit),
        .cmd_restrict (cmd_restrict),
        .read_ok      (read_ok)
    );

    cke_state_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .reinit       (reinit),
        .cke_prev     (cke_prev),
        .cke          (cke),
        .cmd          (cmd),
        .bank_open    (bank_open),
        .busy         (busy),
        .early_change (early_change),
        .cmd_restrict (cmd_restrict),
        .read_ok      (read_ok),
        .state        (state),
        .err          (err),
        .sref_exit    (sref_exit)
    );

    assign state_onehot = state;
    assign read_allowed = read_ok && (state == PS_NORMAL);

    // R6: an early clock-enable change must reach the error flag
    assert_hold_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (early_change && !reinit) |=> err);

    // R9: no read permission directly after leaving self-refresh
    assert_exit_blocks_read_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(state == PS_SELF_REF) |-> !read_allowed);

endmodule

// File: tb/sim_cke_power_tracker.sv
module sim_cke_power_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 3;
    localparam int NRD  = 10;
    localparam int RD   = 200;

    logic       clk = 1'b0;
    logic       rst, reinit, cke, bank_open, busy;
    logic [2:0] cmd;
    logic [3:0] state_onehot;
    logic       err, read_allowed;

    int n_chk = 0;
    int n_fail = 0;

    logic [3:0] m_st;
    logic       m_prev, m_err;
    int         m_hold, m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    cke_power_tracker #(.HOLD_EDGES(HOLD), .NRD_CLKS(NRD), .RD_CLKS(RD)) u0 (
        .clk(clk), .rst(rst), .reinit(reinit), .cke(cke), .cmd(cmd),
        .bank_open(bank_open), .busy(busy), .state_onehot(state_onehot),
        .err(err), .read_allowed(read_allowed)
    );

    function automatic bit quiet_f(input logic [2:0] c);
        return (c == 3'd0) || (c == 3'd1);
    endfunction

    function automatic bit exp_rd();
        return (m_st == 4'b0001) && (m_cnt >= RD);
    endfunction

    task automatic model_reset();
        m_st = 4'b0001; m_prev = 1'b1; m_err = 1'b0; m_hold = HOLD; m_cnt = RD;
    endtask

    task automatic model_edge(input logic k, input logic [2:0] c,
                              input logic bo, input logic bz, input logic ri);
        bit q = quiet_f(c);
        bit bad = 0;
        bit ex = 0;
        logic [3:0] nx = m_st;
        if (!m_prev && !k) begin
            if (m_st == 4'b0001) bad = 1;
        end else if (!m_prev && k) begin
            if (m_st == 4'b0001 || !q) bad = 1;
            else begin nx = 4'b0001; ex = (m_st == 4'b1000); end
        end else if (m_prev && !k) begin
            if (m_st != 4'b0001 || bz) bad = 1;
            else if (q) nx = bo ? 4'b0010 : 4'b0100;
            else if (c == 3'd2 && !bo) nx = 4'b1000;
            else bad = 1;
        end else begin
            if (m_st != 4'b0001) bad = 1;
            else if (m_cnt < NRD && !q) bad = 1;
            else if (c == 3'd3 && m_cnt < RD) bad = 1;
        end
        if (k != m_prev && m_hold < HOLD) bad = 1;
        m_err  = ri ? 1'b0 : (m_err | bad);
        m_hold = (k != m_prev) ? 1 : ((m_hold < HOLD) ? m_hold + 1 : HOLD);
        m_prev = k;
        m_cnt  = ex ? 1 : ((m_cnt < RD) ? m_cnt + 1 : RD);
        m_st   = nx;
    endtask

    task automatic chk(input string tag);
        n_chk++;
        if (state_onehot !== m_st || err !== m_err || read_allowed !== exp_rd()) begin
            n_fail++;
            $display("FAIL %s state=%b/%b err=%b/%b rd=%b/%b", tag,
                     state_onehot, m_st, err, m_err, read_allowed, exp_rd());
        end
    endtask

    // drive at negedge, model the edge, compare at the following negedge
    task automatic step(input logic k, input logic [2:0] c, input logic bo,
                        input logic bz, input logic ri, input string tag);
        cke = k; cmd = c; bank_open = bo; busy = bz; reinit = ri;
        @(posedge clk);
        model_edge(k, c, bo, bz, ri);
        @(negedge clk);
        chk(tag);
    endtask

    task automatic settle_high(input string tag);
        for (int i = 0; i < 3; i++) step(1'b1, 3'd0, 1'b0, 1'b0, 1'b1, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; reinit = 1'b0; cke = 1'b1; cmd = 3'd0; bank_open = 1'b0; busy = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset");

        // R10: normal commands with cke held high
        step(1, 3'd0, 0, 0, 0, "R10");
        step(1, 3'd3, 1, 0, 0, "R10");
        step(1, 3'd5, 1, 1, 0, "R10");

        // R2 active power-down, R4 low-low ignores cmd, R5 exit
        step(0, 3'd0, 1, 0, 0, "R2 apd");
        step(0, 3'd3, 1, 0, 0, "R4");
        step(0, 3'd6, 0, 1, 0, "R4");
        step(1, 3'd1, 1, 0, 0, "R5 exit");
        step(1, 3'd0, 0, 0, 0, "R10");
        step(1, 3'd0, 0, 0, 0, "R10");

        // R2 precharge power-down
        step(0, 3'd1, 0, 0, 0, "R2 ppd");
        step(0, 3'd4, 0, 0, 0, "R4");
        step(0, 3'd2, 0, 0, 0, "R4");
        step(1, 3'd0, 0, 0, 0, "R5 exit");
        step(1, 3'd0, 0, 0, 0, "R10");
        step(1, 3'd0, 0, 0, 0, "R10");

        // R3 self-refresh entry, R9 read window
        step(0, 3'd2, 0, 0, 0, "R3 sref");
        step(0, 3'd0, 0, 0, 0, "R4");
        step(0, 3'd3, 0, 0, 0, "R4");
        step(1, 3'd0, 0, 0, 0, "R9 exit");
        for (int i = 0; i < RD - 1; i++) step(1, (i < NRD) ? 3'd0 : 3'd4, 1, 0, 0, "R9 wait");
        step(1, 3'd3, 1, 0, 0, "R9 read ok");

        // R8 non-quiet command inside the exit window
        step(0, 3'd2, 0, 0, 0, "R3");
        step(0, 3'd0, 0, 0, 0, "R4");
        step(0, 3'd0, 0, 0, 0, "R4");
        step(1, 3'd1, 0, 0, 0, "R5");
        step(1, 3'd4, 0, 0, 0, "R8 early cmd");
        step(1, 3'd0, 0, 0, 0, "R11 sticky");
        step(1, 3'd0, 0, 0, 1, "R11 clear");
        for (int i = 0; i < NRD; i++) step(1, 3'd0, 0, 0, 0, "R9 wait");
        step(1, 3'd3, 0, 0, 0, "R9 early read");
        step(1, 3'd0, 0, 0, 1, "R11 clear");
        for (int i = 0; i < RD; i++) step(1, 3'd0, 0, 0, 0, "R9 wait");

        // R3 refresh entry with an open bank
        step(0, 3'd2, 1, 0, 0, "R3 bank open");
        step(1, 3'd0, 1, 0, 1, "R11 clear");
        settle_high("R10");

        // R7 busy on entry
        step(0, 3'd0, 1, 1, 0, "R7 busy");
        step(1, 3'd0, 1, 0, 1, "R11 clear");
        settle_high("R10");

        // R6 early clock-enable change
        step(0, 3'd0, 0, 0, 0, "R2");
        step(1, 3'd0, 0, 0, 0, "R6 early");
        settle_high("R11 clear");

        // R5 bad exit command
        step(0, 3'd0, 1, 0, 0, "R2");
        step(0, 3'd0, 1, 0, 0, "R4");
        step(0, 3'd0, 1, 0, 0, "R4");
        step(1, 3'd3, 1, 0, 0, "R5 bad exit");
        step(1, 3'd0, 1, 0, 0, "R11 sticky");
        step(0, 3'd0, 1, 0, 1, "R11 clear");
        step(0, 3'd0, 1, 0, 0, "R4");
        step(0, 3'd0, 1, 0, 0, "R4");
        step(1, 3'd0, 1, 0, 0, "R5");

        // mixed random traffic
        begin
            int unsigned seed = 32'd7531;
            logic k = 1'b1;
            void'($urandom(seed));
            for (int i = 0; i < 4000; i++) begin
                int unsigned r = $urandom % 100;
                int unsigned c = $urandom % 10;
                logic [2:0] cc;
                if (r < 18) k = ~k;
                cc = (c < 5) ? 3'd0 : (c < 6) ? 3'd1 : (c < 8) ? 3'd2 : (c < 9) ? 3'd3 : 3'd4;
                step(k, cc, 1'($urandom % 2), ($urandom % 10) == 0,
                     ($urandom % 25) == 0, "R10 random");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule